// File: doc/BRIEF.md
# Leftmost Matching Bit Detector

This combinational unit scans a source operand from its most significant active bit down toward bit 0 and reports the position of the first bit whose value equals a reference polarity. With polarity 1 it finds the leftmost set bit. With polarity 0 it finds the leftmost clear bit. The polarity comes from bit 0 of the second operand. That operand is an 8-bit immediate when the immediate-enable input is high, and a full register value otherwise.

The source can be treated as 8, 16 or 32 bits wide. Bits above the active width never take part in the search. When no active bit matches, the unit returns the fixed code 32, whatever the width. The result settles in the same cycle the inputs change, so an execute stage can write it back without an extra pipeline slot.

The search core is a priority encoder over a width-masked match vector. A parameter chooses between two encoder structures: a linear scan or a balanced binary tree.

Top module: `lmbd_scan`

## Requirements
- R1: The reference polarity is `imm_val[0]` when `imm_en` is 1 and `rs2_val[0]` when `imm_en` is 0. The unselected operand and all other bits of the selected operand have no effect on the result.
- R2: With polarity 1, the result is the index of the highest set bit within the active width.
- R3: With polarity 0, the result is the index of the highest clear bit within the active width.
- R4: `width_sel` encodes the active width: 2'b00 selects 8 bits, 2'b01 selects 16 bits and 2'b10 selects 32 bits. The scan begins at bit (active width − 1).
- R5: Source bits at or above the active width are ignored, even when they hold matching values.
- R6: When no bit inside the active width matches, the result is 32 (6'b100000) for every active width.
- R7: The unit holds no state. `result` follows its inputs without any clock edge.
- R8: `width_sel` = 2'b11 behaves exactly like 2'b10 (the full 32 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 32 | Operand that is scanned |
| width_sel | input | 2 | Active-width code of the source |
| imm_en | input | 1 | Selects the immediate as second operand |
| imm_val | input | 8 | Immediate second operand |
| rs2_val | input | 32 | Register second operand |
| result | output | 6 | Index of the leftmost matching bit, or 32 when none matches |

## Verification
Width masking and the not-found code can both apply to the same input. This happens when the only matching bits of a source lie above the active width. The bench provokes it with patterns such as 32'hFFFF_0000 under a 16-bit width with polarity 1. It then checks that the result is 32 and not the index of a masked bit. A second kind of overlap arises when the immediate and the register disagree in bit 0. The same source is applied under both `imm_en` values, and the two results must differ as the polarity rule predicts.

// File: rtl/lmbd_pkg.sv
package lmbd_pkg;

   // Active-width codes for the scanned operand.
   typedef enum logic [1:0] {
      LW_BYTE = 2'b00,
      LW_HALF = 2'b01,
      LW_WORD = 2'b10,
      LW_WIDE = 2'b11
   } lmbd_width_e;

   // Priority-encoder structure selector.
   localparam int ENC_LINEAR = 0;
   localparam int ENC_TREE   = 1;

   // Number of byte lanes a width code enables, clamped to the lanes present.
   function automatic int unsigned lanes_for_code(input logic [1:0] code,
                                                  input int unsigned max_lanes);
      int unsigned want;
      want = 32'd1 << code;
      return (want > max_lanes) ? max_lanes : want;
   endfunction

endpackage

// File: rtl/lmbd_operand_sel.sv
module lmbd_operand_sel #(
   parameter int IMM_W = 8,
   parameter int RS2_W = 32
) (
   input  logic             imm_en,
   input  logic [IMM_W-1:0] imm_val,
   input  logic [RS2_W-1:0] rs2_val,
   output logic             polarity
);

   if (IMM_W < 1 || RS2_W < 1) begin : g_bad_w
      $error("lmbd_operand_sel: operand widths must be positive");
   end

   // Only bit 0 of whichever operand is selected carries meaning.
   always_comb begin
      polarity = imm_en ? imm_val[0] : rs2_val[0];
   end

endmodule

// File: rtl/lmbd_width_mask.sv
module lmbd_width_mask #(
   parameter int SRC_W  = 32,
   parameter int LANE_W = 8
) (
   input  logic [1:0]       width_sel,
   output logic [SRC_W-1:0] mask
);

   localparam int LANES = SRC_W / LANE_W;

   if (LANE_W < 1 || (SRC_W % LANE_W) != 0) begin : g_bad_lane
      $error("lmbd_width_mask: SRC_W must be a multiple of LANE_W");
   end

   int unsigned active_lanes;
   always_comb begin
      active_lanes = lmbd_pkg::lanes_for_code(width_sel, LANES);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mask[g*LANE_W +: LANE_W] = {LANE_W{active_lanes > 32'(g)}};
   end

endmodule

// File: rtl/lmbd_match_vec.sv
module lmbd_match_vec #(
   parameter int SRC_W = 32
) (
   input  logic [SRC_W-1:0] src_val,
   input  logic [SRC_W-1:0] mask,
   input  logic             polarity,
   output logic [SRC_W-1:0] match
);

   // A bit matches when it equals the polarity and lies inside the width.
   for (genvar b = 0; b < SRC_W; b++) begin : g_bit
      assign match[b] = mask[b] & ~(src_val[b] ^ polarity);
   end

endmodule

// File: rtl/lmbd_prio_enc.sv
module lmbd_prio_enc #(
   parameter int N     = 32,
   parameter int STYLE = lmbd_pkg::ENC_TREE,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   localparam int LOG = $clog2(N);

   if (N < 2 || (1 << LOG) != N) begin : g_bad_n
      $error("lmbd_prio_enc: N must be a power of two of at least 2");
   end

   if (STYLE == lmbd_pkg::ENC_LINEAR) begin : g_linear
      // Upward walk: the last hit seen is the highest index.
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
               found = 1'b1;
               idx   = IW'(i);
            end
         end
      end
   end else begin : g_tree
      // Heap layout: node k has children 2k (lower half) and 2k+1 (upper).
      // Leaves sit at N..2N-1, leaf N+i carrying vec[i].
      logic [2*N-1:1]  hv;
      logic [IW-1:0]   hix [1:2*N-1];

      for (genvar i = 0; i < N; i++) begin : g_leaf
         assign hv[N+i]  = vec[i];
         assign hix[N+i] = '0;
      end

      for (genvar h = 1; h <= LOG; h++) begin : g_level
         localparam int BASE = N >> h;
         for (genvar j = 0; j < BASE; j++) begin : g_node
            localparam int K = BASE + j;
            assign hv[K]  = hv[2*K] | hv[2*K+1];
            assign hix[K] = hv[2*K+1] ? (hix[2*K+1] | IW'(1 << (h-1)))
                                      : hix[2*K];
         end
      end

      assign found = hv[1];
      assign idx   = hix[1];
   end

   // Encoder agrees with its input vector.
   always_comb begin
      if (!$isunknown(vec)) begin
         p_found_any_r6: assert (found == (|vec))
            else $error("encoder found flag disagrees with vector");
         if (found) begin
            p_idx_hit_r2: assert (vec[idx])
               else $error("encoder index points at a zero bit");
         end
      end
   end

endmodule

// File: rtl/lmbd_scan.sv
module lmbd_scan #(
   parameter int SRC_W     = 32,
   parameter int IMM_W     = 8,
   parameter int RS2_W     = 32,
   parameter int LANE_W    = 8,
   parameter int ENC_STYLE = lmbd_pkg::ENC_TREE,
   localparam int IDX_W    = $clog2(SRC_W),
   localparam int RES_W    = IDX_W + 1
) (
   input  logic [SRC_W-1:0] src_val,
   input  logic [1:0]       width_sel,
   input  logic             imm_en,
   input  logic [IMM_W-1:0] imm_val,
   input  logic [RS2_W-1:0] rs2_val,
   output logic [RES_W-1:0] result
);

   localparam logic [RES_W-1:0] MISS_CODE = RES_W'(SRC_W);

   if ((1 << IDX_W) != SRC_W) begin : g_bad_src
      $error("lmbd_scan: SRC_W must be a power of two");
   end
   if (ENC_STYLE != lmbd_pkg::ENC_LINEAR && ENC_STYLE != lmbd_pkg::ENC_TREE) begin : g_bad_style
      $error("lmbd_scan: unknown ENC_STYLE");
   end

   logic             polarity;
   logic [SRC_W-1:0] mask;
   logic [SRC_W-1:0] match;
   logic             found;
   logic [IDX_W-1:0] idx;

   lmbd_operand_sel #(.IMM_W(IMM_W), .RS2_W(RS2_W)) u_opsel (
      .imm_en   (imm_en),
      .imm_val  (imm_val),
      .rs2_val  (rs2_val),
      .polarity (polarity)
   );

   lmbd_width_mask #(.SRC_W(SRC_W), .LANE_W(LANE_W)) u_mask (
      .width_sel (width_sel),
      .mask      (mask)
   );

   lmbd_match_vec #(.SRC_W(SRC_W)) u_match (
      .src_val  (src_val),
      .mask     (mask),
      .polarity (polarity),
      .match    (match)
   );

   lmbd_prio_enc #(.N(SRC_W), .STYLE(ENC_STYLE)) u_enc (
      .vec   (match),
      .found (found),
      .idx   (idx)
   );

   always_comb begin
      result = found ? {1'b0, idx} : MISS_CODE;
   end

   // Cross-checks between the operand, mask, match and encoder stages.
   always_comb begin
      if (!$isunknown({src_val, width_sel, imm_en, imm_val, rs2_val})) begin
         p_in_range_r6: assert (result == MISS_CODE ||
                                 32'(result) < 32'($countones(mask)))
            else $error("result outside active width");
         p_masked_r5: assert ((match & ~mask) == '0)
            else $error("match outside active width");
         if (width_sel == 2'b11) begin
            p_wide_full_r8: assert ($countones(mask) == SRC_W)
               else $error("code 3 did not select full width");
         end
         if (found) begin
            p_polarity_r1: assert (src_val[idx] == (imm_en ? imm_val[0] : rs2_val[0]))
               else $error("reported bit does not equal polarity");
            p_leftmost_r4: assert (((match >> idx) >> 1) == '0)
               else $error("a higher matching bit was skipped");
         end
      end
   end

endmodule

// File: tb/lmbd_scan_tb.sv
module lmbd_scan_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic [31:0] src;
      logic [1:0]  w;
      logic        ie;
      logic [7:0]  imm;
      logic [31:0] rs2;
      logic [5:0]  exp;
   } vec_t;

   localparam int NVEC = 16;
   localparam vec_t VECS [NVEC] = '{
      '{32'h0000_0001, 2'b10, 1'b1, 8'h01, 32'h0000_0000, 6'd0},   // R2 lowest bit
      '{32'h8000_0000, 2'b10, 1'b1, 8'h01, 32'h0000_0000, 6'd31},  // R2 top bit
      '{32'hFFFF_FFFF, 2'b10, 1'b1, 8'h00, 32'h0000_0001, 6'd32},  // R6 no zero
      '{32'h7FFF_FFFF, 2'b10, 1'b0, 8'h01, 32'h0000_0000, 6'd31},  // R3 via rs2
      '{32'hFFFF_FFEF, 2'b10, 1'b1, 8'hFE, 32'h0000_0001, 6'd4},   // R3 deep zero
      '{32'h0000_1234, 2'b01, 1'b1, 8'h03, 32'h0000_0000, 6'd12},  // R4 half
      '{32'hFFFF_0000, 2'b01, 1'b1, 8'h01, 32'h0000_0000, 6'd32},  // R5+R6
      '{32'hABCD_00FF, 2'b00, 1'b1, 8'h00, 32'h0000_0000, 6'd32},  // R5 byte
      '{32'h1234_5680, 2'b00, 1'b1, 8'h01, 32'h0000_0000, 6'd7},   // R4 byte
      '{32'h0000_0040, 2'b00, 1'b1, 8'h00, 32'h0000_0000, 6'd7},   // R3 byte
      '{32'h0000_00BF, 2'b00, 1'b1, 8'h00, 32'h0000_0000, 6'd6},   // R3 byte
      '{32'h0000_0000, 2'b10, 1'b0, 8'h00, 32'h0000_0001, 6'd32},  // R6 zero src
      '{32'h0001_0000, 2'b11, 1'b0, 8'h00, 32'h0000_0001, 6'd16},  // R8
      '{32'h0001_0000, 2'b10, 1'b0, 8'h01, 32'hFFFF_FFFE, 6'd31},  // R1 rs2 pol 0
      '{32'h0001_0000, 2'b10, 1'b1, 8'h01, 32'hFFFF_FFFE, 6'd16},  // R1 imm pol 1
      '{32'h00FF_FF00, 2'b01, 1'b1, 8'h00, 32'h0000_0000, 6'd7}    // R3 half
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_val = '0;
   logic [1:0]  width_sel = '0;
   logic        imm_en = 1'b0;
   logic [7:0]  imm_val = '0;
   logic [31:0] rs2_val = '0;
   logic [5:0]  result;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lmbd_scan u_dut (
      .src_val   (src_val),
      .width_sel (width_sel),
      .imm_en    (imm_en),
      .imm_val   (imm_val),
      .rs2_val   (rs2_val),
      .result    (result)
   );

   function automatic logic [5:0] ref_scan(input logic [31:0] s,
                                           input logic [1:0] w,
                                           input logic pol);
      int n;
      n = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
      for (int i = 31; i >= 0; i--) begin
         if (i < n && s[i] == pol) return 6'(i);
      end
      return 6'd32;
   endfunction

   task automatic check(input string req, input logic [5:0] exp);
      n_checks++;
      if (result !== exp) begin
         n_fails++;
         $display("FAIL %s: result=%0d expected=%0d (src=%h w=%0d ie=%0b imm=%h rs2=%h)",
                  req, result, exp, src_val, width_sel, imm_en, imm_val, rs2_val);
      end
   endtask

   task automatic apply(input logic [31:0] s, input logic [1:0] w, input logic ie,
                        input logic [7:0] im, input logic [31:0] r2);
      @(posedge clk);
      src_val = s; width_sel = w; imm_en = ie; imm_val = im; rs2_val = r2;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Idle inputs: byte width, polarity 0, source zero -> bit 7 (R3, R4).
      check("R4 idle", 6'd7);

      // Vector table (R1..R6, R8).
      for (int k = 0; k < NVEC; k++) begin
         apply(VECS[k].src, VECS[k].w, VECS[k].ie, VECS[k].imm, VECS[k].rs2);
         check($sformatf("R2/R3 vec%0d", k), VECS[k].exp);
      end

      // Single-bit and single-hole sweeps over every width and polarity (R2, R3, R4).
      for (int w = 0; w < 3; w++) begin
         for (int b = 0; b < 32; b++) begin
            apply(32'h1 << b, 2'(w), 1'b1, 8'h01, 32'h0);
            check("R2 sweep", ref_scan(32'h1 << b, 2'(w), 1'b1));
            apply(~(32'h1 << b), 2'(w), 1'b0, 8'h00, 32'hFFFF_FFFE);
            check("R3 sweep", ref_scan(~(32'h1 << b), 2'(w), 1'b0));
         end
      end

      // R5: garbage above the active width must not change the result.
      apply(32'hDEAD_BE00, 2'b00, 1'b1, 8'h01, 32'h0);
      check("R5 upper ignored", 6'd32);
      apply(32'h5A5A_0003, 2'b01, 1'b1, 8'h01, 32'h0);
      check("R5 upper ignored half", 6'd1);

      // R1: non-zero upper bits of selected and unselected operands have no effect.
      apply(32'h0000_F000, 2'b10, 1'b1, 8'hFE, 32'h0000_0001);
      check("R1 imm upper bits", 6'd31);
      apply(32'h0000_F000, 2'b10, 1'b0, 8'h01, 32'hABCD_EF00);
      check("R1 rs2 upper bits", 6'd31);

      // R8: code 3 equals code 2 for a top-bit pattern.
      apply(32'h8000_0001, 2'b11, 1'b1, 8'h01, 32'h0);
      check("R8 wide top", 6'd31);

      // R7: change inputs between edges; result follows without a clock.
      @(negedge clk);
      src_val = 32'h0000_0100; width_sel = 2'b10; imm_en = 1'b1; imm_val = 8'h01;
      #1;
      check("R7 no clock", 6'd8);
      src_val = 32'h0000_0000;
      #1;
      check("R7 no clock miss", 6'd32);

      finish_run();
   end

endmodule